// File: doc/BRIEF.md
# Fence-aware memory operation sequencer

The sequencer sits between an in-order producer of memory operations and a single memory request port. Each incoming operation is a load, a store, or one of three ordering fences: a store fence, a load fence or a full fence. Loads and stores are held in an issue window and sent to memory as soon as nothing orders them, so a younger operation may pass an older one that is still blocked. Each request carries a tag naming its window slot. Completions return with that tag in any order and free the slot.

A fence is never placed in the window. When a fence is accepted, the window snapshots the older operations that the fence kind orders. Younger operations that the fence orders are parked in a side FIFO in arrival order, and once the FIFO holds anything, every later arrival joins it behind the parked ones. Operations the fence does not order may still enter the window while the FIFO is empty. When every snapshotted operation has completed, a store or full fence also runs a flush handshake on the store buffer. The FIFO is then replayed into the window in order. A fence found at the FIFO head starts a new round.

The control is a four-state machine. SQ_RUN is normal out-of-order operation. SQ_RUN goes to SQ_DRAIN when a fence is accepted. SQ_DRAIN waits for the snapshot to empty, then goes to SQ_FLUSH for store and full fences, or straight to SQ_RELEASE for a load fence. SQ_FLUSH holds the flush request until it is acknowledged, then goes to SQ_RELEASE. SQ_RELEASE pops the FIFO head into the window one entry per cycle. It goes back to SQ_DRAIN when it pops a fence, and to SQ_RUN when the FIFO is empty.

Top module: `memop_sequencer`

## Requirements
- R1: After reset, req_valid and flush_req are 0, and in_ready is 1 for a load.
- R2: Operation kinds are encoded on in_kind as 0 load, 1 store, 2 store fence, 3 load fence and 4 full fence; the codes 5 to 7 act as a full fence. Among the window entries that are free to issue, the lowest slot is offered first. An unblocked younger operation issues past an older one that is blocked, and a store request carries its address and data.
- R3: An operation never issues while an older entry to the same address is still incomplete, if either of the two is a store.
- R4: After a store fence, no younger store issues until every older store has completed. Younger loads arriving while the FIFO is empty still enter the window and issue.
- R5: After a load fence, no younger load issues until every older load has completed. Younger stores arriving while the FIFO is empty still enter the window and issue.
- R6: After a full fence, no younger load or store issues until every older load and store has completed.
- R7: For a store fence or a full fence, flush_req rises only once the older ordered operations have completed. It stays high until flush_ack, and nothing the fence orders issues before then. A load fence never raises flush_req.
- R8: Parked operations, including later fences, are released in arrival order. An operation behind a parked fence waits for that fence to retire.
- R9: in_ready is 0 when the structure the offered operation would enter is full: the 8-entry window for direct entry, or the 8-entry side FIFO for parked entry.
- R10: req_tag is the window slot of the request, and a new entry takes the lowest free slot. A completion may name any outstanding tag, in any order, and frees that slot.
- R11: A request that is not accepted stays valid on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming operation valid |
| in_ready | output | 1 | Incoming operation accepted this cycle |
| in_kind | input | 3 | Operation kind code |
| in_addr | input | AW | Operation address |
| in_data | input | DW | Store data |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory port accepts the request |
| req_is_store | output | 1 | Request is a store |
| req_addr | output | AW | Request address |
| req_data | output | DW | Request store data |
| req_tag | output | log2(NE) | Request tag (window slot) |
| cpl_valid | input | 1 | Completion strobe |
| cpl_tag | input | log2(NE) | Tag of the completed request |
| flush_req | output | 1 | Store buffer flush request |
| flush_ack | input | 1 | Store buffer flush done |

## Verification
The bench targets a load stuck behind an older store to the same address while a younger load to another address passes it. A design without the address check would return stale data, and a strictly in-order design would stall the younger load. For each fence kind, the bench checks that the class of operation the fence does not order slips through, and that the ordered class stays put until the completions arrive. A design that mixed up the fence classes would either stall the wrong traffic or let a store overtake a fence. A chain made of a full fence, a parked store fence and a parked load checks that the replay keeps arrival order and that the flush happens only after the last older store. Filling the window and then the FIFO checks that in_ready drops for each structure, and with the port stalled, that a pending request does not disappear.

// File: rtl/memop_pkg.sv
package memop_pkg;

    typedef enum logic [2:0] {
        OP_LOAD      = 3'd0,
        OP_STORE     = 3'd1,
        OP_FENCE_ST  = 3'd2,
        OP_FENCE_LD  = 3'd3,
        OP_FENCE_ALL = 3'd4
    } op_kind_e;

    typedef enum logic [1:0] {
        SQ_RUN,
        SQ_DRAIN,
        SQ_FLUSH,
        SQ_RELEASE
    } sq_state_e;

    function automatic logic is_fence(input logic [2:0] k);
        return k >= 3'd2;
    endfunction

    // fence kind orders loads
    function automatic logic holds_ld(input logic [2:0] k);
        return k != OP_FENCE_ST;
    endfunction

    // fence kind orders stores (and needs a store buffer flush)
    function automatic logic holds_st(input logic [2:0] k);
        return k != OP_FENCE_LD;
    endfunction

endpackage

// File: rtl/memop_pick.sv
module memop_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]         req,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/memop_fifo.sv
module memop_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] mem_q [DEPTH];
    logic [PW:0]  wp_q, rp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[wp_q[PW-1:0]] <= wdata;
    end

    assign rdata = mem_q[rp_q[PW-1:0]];
    assign empty = (wp_q == rp_q);
    assign full  = (wp_q[PW] != rp_q[PW]) && (wp_q[PW-1:0] == rp_q[PW-1:0]);
endmodule

// File: rtl/memop_window.sv
module memop_window #(
    parameter int NE = 8,
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc,
    input  logic                  alloc_store,
    input  logic [AW-1:0]         alloc_addr,
    input  logic [DW-1:0]         alloc_data,
    output logic                  have_free,
    input  logic                  iss_fire,
    input  logic                  cpl_valid,
    input  logic [$clog2(NE)-1:0] cpl_tag,
    output logic                  req_valid,
    output logic                  req_store,
    output logic [AW-1:0]         req_addr,
    output logic [DW-1:0]         req_data,
    output logic [$clog2(NE)-1:0] req_tag,
    output logic [NE-1:0]         vld_vec,
    output logic [NE-1:0]         sto_vec
);
    localparam int IW = $clog2(NE);

    logic [NE-1:0] vld_q, iss_q, sto_q, elig, done_vec;
    logic [NE-1:0] older_q [NE];
    logic [AW-1:0] addr_q  [NE];
    logic [DW-1:0] data_q  [NE];
    logic [IW-1:0] slot, sel;

    memop_pick #(.N(NE)) u_free (.req(~vld_q), .found(have_free), .idx(slot));
    memop_pick #(.N(NE)) u_sel  (.req(elig),   .found(req_valid), .idx(sel));

    assign done_vec = cpl_valid ? (vld_q & iss_q & (NE'(1) << cpl_tag)) : '0;

    generate
        for (genvar g = 0; g < NE; g++) begin : g_ent
            logic hazard;
            always_comb begin
                hazard = 1'b0;
                for (int j = 0; j < NE; j++) begin
                    if (older_q[g][j] && vld_q[j] && (addr_q[j] == addr_q[g]) &&
                        (sto_q[g] || sto_q[j]))
                        hazard = 1'b1;
                end
            end
            assign elig[g] = vld_q[g] & ~iss_q[g] & ~hazard;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            iss_q <= '0;
            for (int i = 0; i < NE; i++) older_q[i] <= '0;
        end else begin
            for (int i = 0; i < NE; i++) begin
                if (alloc && (slot == IW'(i))) begin
                    vld_q[i]   <= 1'b1;
                    iss_q[i]   <= 1'b0;
                    older_q[i] <= vld_q;
                end else begin
                    if (done_vec[i]) begin
                        vld_q[i] <= 1'b0;
                        iss_q[i] <= 1'b0;
                    end else if (iss_fire && (sel == IW'(i))) begin
                        iss_q[i] <= 1'b1;
                    end
                    if (alloc) older_q[i][slot] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (alloc) begin
            addr_q[slot] <= alloc_addr;
            data_q[slot] <= alloc_data;
            sto_q[slot]  <= alloc_store;
        end
    end

    assign req_store = sto_q[sel];
    assign req_addr  = addr_q[sel];
    assign req_data  = data_q[sel];
    assign req_tag   = sel;
    assign vld_vec   = vld_q;
    assign sto_vec   = sto_q;
endmodule

// File: rtl/memop_sequencer.sv
module memop_sequencer
    import memop_pkg::*;
#(
    parameter int NE = 8,
    parameter int FD = 8,
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [2:0]            in_kind,
    input  logic [AW-1:0]         in_addr,
    input  logic [DW-1:0]         in_data,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic                  req_is_store,
    output logic [AW-1:0]         req_addr,
    output logic [DW-1:0]         req_data,
    output logic [$clog2(NE)-1:0] req_tag,
    input  logic                  cpl_valid,
    input  logic [$clog2(NE)-1:0] cpl_tag,
    output logic                  flush_req,
    input  logic                  flush_ack
);
    localparam int FW = 3 + AW + DW;

    sq_state_e     st_q, st_n;
    logic [2:0]    fk_q, fk_n;
    logic [NE-1:0] mask_q, mask_n, cls, done_all;
    logic [NE-1:0] vld_vec, sto_vec;

    logic          have_free, alloc, a_store, from_fifo;
    logic [AW-1:0] a_addr;
    logic [DW-1:0] a_data;
    logic          f_push, f_pop, f_empty, f_full, snap;
    logic [FW-1:0] f_rd;
    logic [2:0]    hd_kind;
    logic [AW-1:0] hd_addr;
    logic [DW-1:0] hd_data;
    logic          ordered_in, bypass;

    memop_fifo #(.DEPTH(FD), .W(FW)) u_park (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (f_push),
        .pop   (f_pop),
        .wdata ({in_kind, in_addr, in_data}),
        .rdata (f_rd),
        .empty (f_empty),
        .full  (f_full)
    );

    assign hd_kind = f_rd[FW-1 -: 3];
    assign hd_addr = f_rd[DW +: AW];
    assign hd_data = f_rd[DW-1:0];

    assign from_fifo = (st_q == SQ_RELEASE);
    assign a_store   = from_fifo ? (hd_kind == OP_STORE) : (in_kind == OP_STORE);
    assign a_addr    = from_fifo ? hd_addr : in_addr;
    assign a_data    = from_fifo ? hd_data : in_data;

    memop_window #(.NE(NE), .AW(AW), .DW(DW)) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc       (alloc),
        .alloc_store (a_store),
        .alloc_addr  (a_addr),
        .alloc_data  (a_data),
        .have_free   (have_free),
        .iss_fire    (req_valid && req_ready),
        .cpl_valid   (cpl_valid),
        .cpl_tag     (cpl_tag),
        .req_valid   (req_valid),
        .req_store   (req_is_store),
        .req_addr    (req_addr),
        .req_data    (req_data),
        .req_tag     (req_tag),
        .vld_vec     (vld_vec),
        .sto_vec     (sto_vec)
    );

    assign ordered_in = is_fence(in_kind) |
                        ((in_kind == OP_LOAD) ? holds_ld(fk_q) : holds_st(fk_q));
    assign bypass     = f_empty && !ordered_in;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SQ_RUN;
            fk_q   <= OP_FENCE_ALL;
            mask_q <= '0;
        end else begin
            st_q   <= st_n;
            fk_q   <= fk_n;
            mask_q <= mask_n;
        end
    end

    // next state and outputs
    always_comb begin
        st_n      = st_q;
        fk_n      = fk_q;
        in_ready  = 1'b0;
        alloc     = 1'b0;
        f_push    = 1'b0;
        f_pop     = 1'b0;
        snap      = 1'b0;
        flush_req = 1'b0;
        unique case (st_q)
            SQ_RUN: begin
                if (is_fence(in_kind)) begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        snap = 1'b1;
                        fk_n = in_kind;
                        st_n = SQ_DRAIN;
                    end
                end else begin
                    in_ready = have_free;
                    alloc    = in_valid && have_free;
                end
            end
            SQ_DRAIN, SQ_FLUSH: begin
                in_ready = bypass ? have_free : !f_full;
                alloc    = in_valid && bypass && have_free;
                f_push   = in_valid && !bypass && !f_full;
                if (st_q == SQ_DRAIN) begin
                    if (mask_q == '0) st_n = holds_st(fk_q) ? SQ_FLUSH : SQ_RELEASE;
                end else begin
                    flush_req = 1'b1;
                    if (flush_ack) st_n = SQ_RELEASE;
                end
            end
            SQ_RELEASE: begin
                if (f_empty) begin
                    st_n = SQ_RUN;
                end else begin
                    in_ready = !f_full;
                    f_push   = in_valid && !f_full;
                    if (is_fence(hd_kind)) begin
                        f_pop = 1'b1;
                        snap  = 1'b1;
                        fk_n  = hd_kind;
                        st_n  = SQ_DRAIN;
                    end else if (have_free) begin
                        f_pop = 1'b1;
                        alloc = 1'b1;
                    end
                end
            end
        endcase
    end

    // snapshot of the older operations the current fence waits for
    always_comb begin
        cls      = (holds_ld(fk_n) ? ~sto_vec : '0) | (holds_st(fk_n) ? sto_vec : '0);
        done_all = cpl_valid ? (NE'(1) << cpl_tag) : '0;
        mask_n   = snap ? (vld_vec & cls & ~done_all) : (mask_q & ~done_all);
    end
endmodule

// File: rtl/memop_sequencer_chk.sv
module memop_sequencer_chk #(
    parameter int NE = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic                  req_is_store,
    input logic [$clog2(NE)-1:0] req_tag,
    input logic                  cpl_valid,
    input logic [$clog2(NE)-1:0] cpl_tag,
    input logic                  flush_req,
    input logic                  flush_ack
);
    logic [NE-1:0] out_q, st_q, out_n, st_n;

    always_comb begin
        out_n = out_q;
        st_n  = st_q;
        if (cpl_valid) begin
            out_n[cpl_tag] = 1'b0;
            st_n[cpl_tag]  = 1'b0;
        end
        if (req_valid && req_ready) begin
            out_n[req_tag] = 1'b1;
            st_n[req_tag]  = req_is_store;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            st_q  <= '0;
        end else begin
            out_q <= out_n;
            st_q  <= st_n;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid);                       // R11
    AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !flush_ack |=> flush_req);                       // R7
    AST_TAG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |-> !out_q[req_tag]);                  // R10
    AST_FLUSH_STORES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (st_q == '0));                                  // R4
endmodule

bind memop_sequencer memop_sequencer_chk #(.NE(NE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_is_store (req_is_store),
    .req_tag      (req_tag),
    .cpl_valid    (cpl_valid),
    .cpl_tag      (cpl_tag),
    .flush_req    (flush_req),
    .flush_ack    (flush_ack)
);

// File: tb/memop_sequencer_tb.sv
module memop_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_kind = 3'd0;
    logic [15:0] in_addr = '0;
    logic [15:0] in_data = '0;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic        req_is_store;
    logic [15:0] req_addr;
    logic [15:0] req_data;
    logic [2:0]  req_tag;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_tag = '0;
    logic        flush_req;
    logic        flush_ack = 1'b0;

    localparam logic [2:0] K_LD = 3'd0, K_ST = 3'd1, K_FST = 3'd2, K_FLD = 3'd3, K_FALL = 3'd4;

    always #5 clk = ~clk;

    memop_sequencer u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
        .in_addr(in_addr), .in_data(in_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_is_store(req_is_store),
        .req_addr(req_addr), .req_data(req_data), .req_tag(req_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
        .flush_req(flush_req), .flush_ack(flush_ack)
    );

    int checks = 0;
    int fails  = 0;
    int n_iss  = 0;
    int flush_seen = 0;
    int cycles = 0;
    int log_addr [64];
    int log_tag  [64];
    int log_data [64];
    bit log_st   [64];
    logic [7:0] pend = '0;

    // issue monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (req_valid && req_ready && n_iss < 64) begin
                log_addr[n_iss] = int'(req_addr);
                log_tag[n_iss]  = int'(req_tag);
                log_data[n_iss] = int'(req_data);
                log_st[n_iss]   = req_is_store;
                pend[req_tag]   = 1'b1;
                n_iss++;
            end
            if (flush_req) flush_seen++;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int find(input int a);
        for (int i = 0; i < n_iss; i++) if (log_addr[i] == a) return i;
        return -1;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic [2:0] k, input int a, input int d);
        @(posedge clk); #1;
        in_valid = 1'b1; in_kind = k; in_addr = 16'(a); in_data = 16'(d);
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic probe(input logic [2:0] k, input int a, output bit rdy);
        @(posedge clk); #1;
        in_valid = 1'b1; in_kind = k; in_addr = 16'(a);
        @(negedge clk);
        rdy = in_ready;
        #1 in_valid = 1'b0;
    endtask

    task automatic cpl(input int t);
        @(posedge clk); #1;
        cpl_valid = 1'b1; cpl_tag = 3'(t); pend[t] = 1'b0;
        @(posedge clk); #1;
        cpl_valid = 1'b0;
    endtask

    task automatic cpl_pend();
        for (int t = 0; t < 8; t++) if (pend[t]) cpl(t);
    endtask

    task automatic ack();
        @(posedge clk); #1 flush_ack = 1'b1;
        @(posedge clk); #1 flush_ack = 1'b0;
    endtask

    task automatic drain_all();
        repeat (400) begin
            @(posedge clk); #1;
            flush_ack = flush_req;
            cpl_valid = 1'b0;
            for (int t = 0; t < 8; t++) begin
                if (pend[t] && !cpl_valid) begin
                    cpl_valid = 1'b1; cpl_tag = 3'(t); pend[t] = 1'b0;
                end
            end
        end
        @(posedge clk); #1;
        cpl_valid = 1'b0; flush_ack = 1'b0;
    endtask

    initial begin
        bit rdy;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_valid == 1'b0, "R1 req_valid", int'(req_valid), 0);
        chk(flush_req == 1'b0, "R1 flush_req", int'(flush_req), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        // R2/R3: hazard and out-of-order pass
        req_ready = 1'b0;
        send(K_ST, 'h10, 1);
        send(K_LD, 'h10, 0);
        send(K_LD, 'h20, 0);
        @(posedge clk); #1 req_ready = 1'b1;
        idle(4);
        chk(n_iss == 2, "R3 same-address load held", n_iss, 2);
        chk(log_addr[0] == 'h10 && log_st[0] && log_data[0] == 1, "R2 store first with data", log_data[0], 1);
        chk(log_addr[1] == 'h20, "R2 younger load passes", log_addr[1], 'h20);
        cpl(0);
        idle(4);
        chk(find('h10) == 0 && n_iss == 3 && log_addr[2] == 'h10, "R3 load after store completes", log_addr[2], 'h10);
        chk(log_tag[2] == 1, "R10 tag is slot", log_tag[2], 1);
        cpl(2);
        cpl(1);

        // R4 store fence
        send(K_ST, 'h30, 3);
        send(K_FST, 0, 0);
        send(K_LD, 'h32, 0);
        send(K_ST, 'h31, 4);
        idle(4);
        chk(log_tag[find('h30)] == 0, "R10 freed slots reused", log_tag[find('h30)], 0);
        chk(find('h32) >= 0, "R4 load passes store fence", find('h32), 1);
        chk(find('h31) < 0, "R4 younger store held", find('h31), -1);
        chk(flush_req == 1'b0, "R7 no flush before older store done", int'(flush_req), 0);
        cpl(0);
        idle(3);
        chk(flush_req == 1'b1, "R7 flush after older stores", int'(flush_req), 1);
        chk(find('h31) < 0, "R7 store held during flush", find('h31), -1);
        ack();
        idle(4);
        chk(find('h31) >= 0, "R4 store released after fence", find('h31), 1);
        chk(log_tag[find('h31)] == 0, "R10 lowest free slot", log_tag[find('h31)], 0);
        cpl_pend();

        // R5 load fence
        idle(2);
        flush_seen = 0;
        send(K_LD, 'h40, 0);
        send(K_FLD, 0, 0);
        send(K_ST, 'h41, 5);
        send(K_LD, 'h42, 0);
        idle(4);
        chk(find('h41) >= 0, "R5 store passes load fence", find('h41), 1);
        chk(find('h42) < 0, "R5 younger load held", find('h42), -1);
        cpl_pend();
        idle(5);
        chk(find('h42) >= 0, "R5 load released", find('h42), 1);
        chk(flush_seen == 0, "R7 load fence needs no flush", flush_seen, 0);
        cpl_pend();

        // R6 full fence, R8 order with a parked fence
        send(K_LD, 'h50, 0);
        send(K_ST, 'h51, 6);
        send(K_FALL, 0, 0);
        send(K_LD, 'h52, 0);
        send(K_ST, 'h53, 7);
        send(K_FST, 0, 0);
        send(K_LD, 'h54, 0);
        idle(4);
        chk(find('h52) < 0 && find('h53) < 0, "R6 full fence holds load and store", find('h52), -1);
        cpl_pend();
        idle(3);
        chk(flush_req == 1'b1, "R6 full fence flushes", int'(flush_req), 1);
        ack();
        idle(5);
        chk(find('h52) >= 0 && find('h53) > find('h52), "R8 released in arrival order", find('h53), find('h52) + 1);
        chk(find('h54) < 0, "R8 load behind parked fence held", find('h54), -1);
        cpl_pend();
        idle(3);
        chk(flush_req == 1'b1, "R8 parked fence flushes", int'(flush_req), 1);
        ack();
        idle(5);
        chk(find('h54) >= 0, "R8 load after parked fence", find('h54), 1);
        cpl_pend();

        // R9 capacity, R11 hold
        idle(2);
        @(posedge clk); #1 req_ready = 1'b0;
        for (int i = 0; i < 8; i++) send(K_LD, 'h60 + i, 0);
        probe(K_LD, 'h70, rdy);
        chk(rdy == 1'b0, "R9 window full", int'(rdy), 0);
        idle(3);
        chk(req_valid && req_tag == 0 && req_addr == 16'h60, "R11 request held", int'(req_addr), 'h60);
        send(K_FALL, 0, 0);
        for (int i = 0; i < 8; i++) send(K_ST, 'h80 + i, i);
        probe(K_LD, 'h90, rdy);
        chk(rdy == 1'b0, "R9 side FIFO full", int'(rdy), 0);
        @(posedge clk); #1 req_ready = 1'b1;
        drain_all();
        chk(n_iss == 30, "R9 all accepted operations issued", n_iss, 30);
        chk(find('h87) > find('h67), "R6 stores after older loads", find('h87), find('h67) + 1);
        chk(flush_req == 1'b0 && req_valid == 1'b0, "R1 idle at end", int'(req_valid), 0);
        summary();
    end
endmodule